// File: doc/BRIEF.md
# Shadowed SRAM Strobe Mode Decoder

This block sits behind the four active-low control strobes of a byte-wide SRAM that has a nonvolatile shadow array. The strobes are chip select, output enable, write strobe and shadow enable. It synchronizes them to the system clock and classifies each combination into exactly one of eight operating modes, presented as a one-hot vector.

Alongside the mode vector it produces three qualifiers. The first turns on the 8-bit tristate data drivers. The second flags a strobe combination that must never happen. The third blocks any array store while output enable is low. The memory arrays, the command-sequence tracking and the transfer timers that consume these outputs are outside this block.

The shadow enable strobe lays the recall and command modes over the ordinary SRAM decode. While it is low, the data bus stays released.

Top module: `nvsram_mode_dec`

## Requirements
- R1: `mode_o` is always one-hot. Bit 0 is standby, bit 1 RAM read, bit 2 RAM write, bit 3 recall request, bit 4 command write, bit 5 output disabled, bit 6 illegal and bit 7 no-op.
- R2: When chip select is high, the mode is standby (bit 0) whatever the other strobes are, and the data bus is not driven.
- R3: Chip select and output enable low, with write strobe and shadow enable high, decode as RAM read (bit 1).
- R4: Chip select and write strobe low, with shadow enable and output enable high, decode as RAM write (bit 2).
- R5: Chip select, shadow enable and output enable low, with write strobe high, decode as recall request (bit 3).
- R6: Chip select, shadow enable and write strobe low, with output enable high, decode as command write (bit 4).
- R7: Chip select low with the other three strobes high decodes as output disabled (bit 5). Chip select and shadow enable low, with write strobe and output enable high, decode as no-op (bit 7).
- R8: Chip select, write strobe and output enable all low, with shadow enable at either level, decode as illegal (bit 6) and raise `illegal_o`. In every other case `illegal_o` is low.
- R9: `bus_drive_o` is high exactly when chip select and output enable are low and shadow enable is high.
- R10: `store_block_o` is high exactly when output enable is low, regardless of the other strobes.
- R11: Each output reflects the strobes sampled two rising clock edges earlier. During and after reset, before any strobe has been captured, the outputs read standby, with bus off, no store block and no illegal flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select strobe, active low |
| oen_n_i | input | 1 | Output enable strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| shd_n_i | input | 1 | Shadow (nonvolatile) enable strobe, active low |
| mode_o | output | 8 | One-hot operating mode |
| bus_drive_o | output | 1 | Enable for the data-bus output drivers |
| store_block_o | output | 1 | Inhibits array store operations |
| illegal_o | output | 1 | Forbidden strobe combination seen |

## Verification
The assertions take for granted that the strobe pins are idle (all high) while reset is applied. Under that assumption the checker's own delay line of raw pin values lines up with the synchronizer from the first edge. The assertions also assume that every pin value is held for at least one clock edge, so that the value captured is the value driven. The stimulus is applied only on falling clock edges, holds each value for a full cycle and keeps all strobes high throughout reset. The random vectors cover all sixteen strobe combinations, including the illegal ones.

// File: rtl/nvmd_pkg.sv
package nvmd_pkg;

   localparam int unsigned NUM_MODES = 8;

   localparam int unsigned M_STANDBY = 0;
   localparam int unsigned M_READ    = 1;
   localparam int unsigned M_WRITE   = 2;
   localparam int unsigned M_RECALL  = 3;
   localparam int unsigned M_COMMAND = 4;
   localparam int unsigned M_OUTOFF  = 5;
   localparam int unsigned M_ILLEGAL = 6;
   localparam int unsigned M_NOOP    = 7;

   localparam int unsigned STROBE_W = 4;

   typedef struct packed {
      logic cs_n;
      logic oen_n;
      logic wr_n;
      logic shd_n;
   } strobe_t;

   localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, oen_n: 1'b1, wr_n: 1'b1, shd_n: 1'b1};

   typedef struct packed {
      logic [NUM_MODES-1:0] mode;
      logic                 drive;
      logic                 block;
      logic                 illegal;
   } decode_t;

   localparam decode_t DECODE_RESET = '{mode: NUM_MODES'(1) << M_STANDBY,
                                        drive: 1'b0, block: 1'b0, illegal: 1'b0};

endpackage

// File: rtl/nvmd_sync.sv
module nvmd_sync #(
   parameter int unsigned WIDTH     = 4,
   parameter int unsigned STAGES    = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("nvmd_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/nvmd_classify.sv
module nvmd_classify
   import nvmd_pkg::*;
(
   input  strobe_t strb_i,
   output decode_t dec_o
);

   logic [NUM_MODES-1:0] mode_d;
   logic                 ill_d;

   always_comb begin
      mode_d = '0;
      ill_d  = 1'b0;
      if (strb_i.cs_n) begin
         mode_d[M_STANDBY] = 1'b1;
      end else begin
         unique case ({strb_i.wr_n, strb_i.shd_n, strb_i.oen_n})
            3'b110:  mode_d[M_READ]    = 1'b1;
            3'b011:  mode_d[M_WRITE]   = 1'b1;
            3'b100:  mode_d[M_RECALL]  = 1'b1;
            3'b001:  mode_d[M_COMMAND] = 1'b1;
            3'b111:  mode_d[M_OUTOFF]  = 1'b1;
            3'b101:  mode_d[M_NOOP]    = 1'b1;
            default: begin
               mode_d[M_ILLEGAL] = 1'b1;
               ill_d             = 1'b1;
            end
         endcase
      end
   end

   assign dec_o.mode    = mode_d;
   assign dec_o.illegal = ill_d;
   assign dec_o.drive   = ~strb_i.cs_n & ~strb_i.oen_n & strb_i.shd_n;
   assign dec_o.block   = ~strb_i.oen_n;

endmodule

// File: rtl/nvmd_outstage.sv
module nvmd_outstage
   import nvmd_pkg::*;
#(
   parameter bit REGISTERED = 1'b0
) (
   input  logic    clk,
   input  logic    rst_n,
   input  decode_t dec_i,
   output decode_t dec_o
);

   if (REGISTERED) begin : g_reg
      decode_t dec_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dec_q <= DECODE_RESET;
         else        dec_q <= dec_i;
      end
      assign dec_o = dec_q;
   end else begin : g_pass
      assign dec_o = dec_i;
   end

endmodule

// File: rtl/nvsram_mode_dec.sv
module nvsram_mode_dec
   import nvmd_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          REG_OUT     = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_n_i,
   input  logic                 oen_n_i,
   input  logic                 wr_n_i,
   input  logic                 shd_n_i,
   output logic [NUM_MODES-1:0] mode_o,
   output logic                 bus_drive_o,
   output logic                 store_block_o,
   output logic                 illegal_o
);

   localparam int unsigned LATENCY = SYNC_STAGES + (REG_OUT ? 1 : 0);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("nvsram_mode_dec: SYNC_STAGES must be at least 2");
   end

   strobe_t pins_raw;
   strobe_t pins_sync;
   decode_t dec_comb;
   decode_t dec_out;

   assign pins_raw = '{cs_n: cs_n_i, oen_n: oen_n_i, wr_n: wr_n_i, shd_n: shd_n_i};

   nvmd_sync #(
      .WIDTH  (STROBE_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL(STROBE_IDLE)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (pins_raw),
      .q_o  (pins_sync)
   );

   nvmd_classify u_classify (
      .strb_i(pins_sync),
      .dec_o (dec_comb)
   );

   nvmd_outstage #(
      .REGISTERED(REG_OUT)
   ) u_out (
      .clk  (clk),
      .rst_n(rst_n),
      .dec_i(dec_comb),
      .dec_o(dec_out)
   );

   assign mode_o        = dec_out.mode;
   assign bus_drive_o   = dec_out.drive;
   assign store_block_o = dec_out.block;
   assign illegal_o     = dec_out.illegal;

endmodule

// File: rtl/nvsram_mode_dec_chk.sv
module nvsram_mode_dec_chk
   import nvmd_pkg::*;
#(
   parameter int unsigned LAT = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cs_n_i,
   input logic                 oen_n_i,
   input logic                 wr_n_i,
   input logic                 shd_n_i,
   input logic [NUM_MODES-1:0] mode_o,
   input logic                 bus_drive_o,
   input logic                 store_block_o,
   input logic                 illegal_o
);

   logic [3:0] dly_q [LAT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LAT; i++) dly_q[i] <= 4'hF;
      end else begin
         dly_q[0] <= {cs_n_i, oen_n_i, wr_n_i, shd_n_i};
         for (int i = 1; i < LAT; i++) dly_q[i] <= dly_q[i-1];
      end
   end

   logic c_cs, c_oe, c_wr, c_sh;
   assign {c_cs, c_oe, c_wr, c_sh} = dly_q[LAT-1];

   assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(mode_o));

   assert_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
      c_cs |-> (mode_o[M_STANDBY] && !bus_drive_o));

   assert_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!c_cs && !c_oe && c_wr && c_sh) |-> mode_o[M_READ]);

   assert_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!c_cs && c_oe && !c_wr && c_sh) |-> mode_o[M_WRITE]);

   assert_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o == (!c_cs && !c_oe && !c_wr));

   assert_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_drive_o |-> (!c_cs && !c_oe && c_sh));

   assert_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
      store_block_o == !c_oe);

endmodule

bind nvsram_mode_dec nvsram_mode_dec_chk #(.LAT(LATENCY)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cs_n_i       (cs_n_i),
   .oen_n_i      (oen_n_i),
   .wr_n_i       (wr_n_i),
   .shd_n_i      (shd_n_i),
   .mode_o       (mode_o),
   .bus_drive_o  (bus_drive_o),
   .store_block_o(store_block_o),
   .illegal_o    (illegal_o)
);

// File: tb/nvsram_mode_dec_tb.sv
module nvsram_mode_dec_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, oen_n = 1'b1, wr_n = 1'b1, shd_n = 1'b1;
   logic [7:0] mode;
   logic       drive, block, illegal;

   int unsigned n_vec = 0;
   int unsigned n_bad = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   nvsram_mode_dec u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cs_n_i       (cs_n),
      .oen_n_i      (oen_n),
      .wr_n_i       (wr_n),
      .shd_n_i      (shd_n),
      .mode_o       (mode),
      .bus_drive_o  (drive),
      .store_block_o(block),
      .illegal_o    (illegal)
   );

   // pattern bits: [3]=cs_n [2]=oen_n [1]=wr_n [0]=shd_n
   function automatic logic [7:0] exp_mode(input logic [3:0] p);
      logic c, o, w, s;
      {c, o, w, s} = p;
      if (c)                   return 8'h01;
      if (!o && w && s)        return 8'h02;
      if (o && !w && s)        return 8'h04;
      if (!o && w && !s)       return 8'h08;
      if (o && !w && !s)       return 8'h10;
      if (o && w && s)         return 8'h20;
      if (o && w && !s)        return 8'h80;
      return 8'h40;
   endfunction

   function automatic string mode_tag(input logic [3:0] p);
      logic c, o, w, s;
      {c, o, w, s} = p;
      if (c)                   return "R2";
      if (!o && w && s)        return "R3";
      if (o && !w && s)        return "R4";
      if (!o && w && !s)       return "R5";
      if (o && !w && !s)       return "R6";
      if (o && w)              return "R7";
      return "R8";
   endfunction

   task automatic check_bit(input string tag, input logic act, input logic expv);
      n_vec++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", tag, act, expv);
      end
   endtask

   task automatic check_all(input logic [3:0] p);
      n_vec++;
      if (mode !== exp_mode(p)) begin
         n_bad++;
         $display("FAIL %s: pattern %b mode actual %h expected %h",
                  mode_tag(p), p, mode, exp_mode(p));
      end
      if ($countones(mode) != 1) begin
         n_bad++;
         $display("FAIL R1: mode actual %h expected one-hot", mode);
      end
      check_bit("R8 illegal", illegal, !p[3] && !p[2] && !p[1]);
      check_bit("R9 drive",   drive,   !p[3] && !p[2] && p[0]);
      check_bit("R10 block",  block,   !p[2]);
   endtask

   task automatic drive_pat(input logic [3:0] p);
      {cs_n, oen_n, wr_n, shd_n} = p;
   endtask

   logic [3:0] hist [3];

   // at each falling edge: check what was driven two edges ago, then drive new
   task automatic step(input logic [3:0] p);
      @(negedge clk);
      check_all(hist[1]);
      hist[1] = hist[0];
      hist[0] = p;
      drive_pat(p);
   endtask

   initial begin
      void'($urandom(32'h1D2C_0A55));
      hist[0] = 4'hF; hist[1] = 4'hF; hist[2] = 4'hF;
      repeat (3) @(negedge clk);
      // R11: reset state
      check_bit("R11 reset standby", mode[0], 1'b1);
      check_bit("R11 reset drive",   drive,   1'b0);
      check_bit("R11 reset block",   block,   1'b0);
      check_bit("R11 reset illegal", illegal, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R11: latency of two edges
      drive_pat(4'b0011);
      @(negedge clk);
      check_bit("R11 one edge still standby", mode[0], 1'b1);
      @(negedge clk);
      check_bit("R11 two edges read", mode[1], 1'b1);
      drive_pat(4'hF);
      repeat (3) @(negedge clk);
      // directed: every combination, each held two cycles
      for (int k = 0; k < 16; k++) begin
         step(4'(k));
         step(4'(k));
      end
      // random walk, including back-to-back changes
      for (int k = 0; k < 3000; k++) begin
         step(4'($urandom_range(0, 15)));
      end
      step(4'hF);
      step(4'hF);
      step(4'hF);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule